// File: doc/BRIEF.md
# Two-Wire Wiper Register Command Slave

This block is the serial command front end of a four-channel digital potentiometer controller. It watches a two-wire bus (a clock line and an open-drain data line), recognises START and STOP conditions, and accepts a command only when the first byte carries the fixed type nibble and matches the four device-address pins. A second byte, the instruction, holds an opcode nibble, a two-bit data-register selector and a two-bit channel selector. The block can write a channel's wiper register, read it back, or read one of that channel's four data registers. It acknowledges each accepted byte by pulling the data line low.

Each of the four channels has one 8-bit volatile wiper register and four 8-bit data registers, sixteen data registers in all. The data registers are plain flip-flops. They take their contents from a preload bus while reset is held. In the first cycle after reset is released, every wiper register copies data register 0 of its own channel. The wiper registers drive the wiper position buses.

The controller is one state machine. Its states are S_IDLE, S_ADDR_RX, S_ADDR_CHK, S_ADDR_ACK, S_INSTR_RX, S_INSTR_CHK, S_INSTR_ACK, S_WDATA_RX, S_WDATA_CHK, S_WDATA_ACK, S_RDATA_TX, S_MACK and S_WAIT_STOP.

The transitions are as follows:
- A START from any state leads to S_ADDR_RX. A STOP from any state leads to S_IDLE.
- Each *_RX state moves to its *_CHK state on the eighth received clock rise.
- S_ADDR_CHK goes to S_ADDR_ACK on a good address. Otherwise it goes to S_IDLE.
- S_ADDR_ACK goes to S_INSTR_RX.
- S_INSTR_CHK goes to S_INSTR_ACK on a known opcode. Otherwise it goes to S_IDLE.
- S_INSTR_ACK goes to S_WDATA_RX for a write, or to S_RDATA_TX for a read.
- S_WDATA_CHK goes to S_WDATA_ACK, and S_WDATA_ACK goes to S_WAIT_STOP.
- S_RDATA_TX goes to S_MACK after the eighth bit.
- S_MACK goes to S_WAIT_STOP on the master's acknowledge clock.

All moves that end a bit time take place on a falling bus clock.

Top module: `wiper_cmd_if`

## Requirements
- R1: While reset is held, data register r of channel c takes bits [(c*4+r)*8 +: 8] of the preload bus. No later than two clocks after reset is released, wiper bus c equals data register 0 of channel c, and the data line is released.
- R2: The slave acknowledges an address byte whose bits 7:4 are 0101 and whose bits 3:0 equal the device-address pins. To acknowledge, it holds the data line low during the ninth clock pulse.
- R3: The slave does not acknowledge an address byte with the wrong type nibble or the wrong device address. Until the next START it acknowledges nothing and changes no register.
- R4: Instruction opcode 1010 (bits 7:4) is acknowledged, and so is the data byte that follows it. The data byte is then written into the wiper register of the channel in bits 1:0. Bits 3:2 have no effect.
- R5: After opcode 1001 is acknowledged, the slave sends the wiper register of channel bits 1:0 as eight bits, MSB first. Bits 3:2 have no effect.
- R6: After opcode 1011 is acknowledged, the slave sends data register bits 3:2 of channel bits 1:0 as eight bits, MSB first.
- R7: An instruction byte with any other opcode is not acknowledged. The data byte after it is not acknowledged, and no wiper register changes.
- R8: A START received while a write data byte is partly shifted in abandons that write, so the wiper is unchanged. It also begins a new address phase, so a complete command sent right after it takes effect.
- R9: A STOP in any state returns the slave to idle with the data line released. A complete command sent next is served normally.
- R10: The slave changes the data-line pull only while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin (wired level) |
| dev_addr | input | 4 | Device-address pins compared with address byte bits 3:0 |
| dr_init | input | 128 | Preload value for the sixteen data registers, applied while in reset |
| sda_pull | output | 1 | Open-drain enable: 1 pulls the data line low |
| wiper_pos | output | 32 | Wiper register of channel c on bits [c*8 +: 8] |

## Verification
Two things can land in the same system clock: a START that aborts a write whose data byte is half received, and the opening of a new address phase. The bench provokes this by sending four data bits after a write instruction and then issuing a repeated START. It first checks that a STOP placed right after the abort leaves the wiper unchanged. It then repeats the abort and follows it at once with a full write, and checks that this second write reaches the wiper. A monitor that runs for the whole bench judges the pull line against the bus clock.

// File: rtl/wcmd_pkg.sv
package wcmd_pkg;

    // Address byte type nibble (bits 7:4)
    localparam logic [3:0] TYPE_ID   = 4'b0101;

    // Instruction opcodes (bits 7:4)
    localparam logic [3:0] OP_RD_WCR = 4'b1001;
    localparam logic [3:0] OP_WR_WCR = 4'b1010;
    localparam logic [3:0] OP_RD_DR  = 4'b1011;

    // Selector field width fixed by the instruction byte layout
    localparam int SEL_W = 2;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR_RX,
        S_ADDR_CHK,
        S_ADDR_ACK,
        S_INSTR_RX,
        S_INSTR_CHK,
        S_INSTR_ACK,
        S_WDATA_RX,
        S_WDATA_CHK,
        S_WDATA_ACK,
        S_RDATA_TX,
        S_MACK,
        S_WAIT_STOP
    } ctl_state_e;

endpackage

// File: rtl/wcmd_line_sync.sv
module wcmd_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_hi,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_bit,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;
    logic              sda_s;

    assign scl_s = scl_sh[STAGES-1];
    assign sda_s = sda_sh[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_in};
            sda_sh <= {sda_sh[STAGES-2:0], sda_in};
            scl_q  <= scl_s;
            sda_q  <= sda_s;
        end
    end

    assign scl_hi    = scl_s;
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign sda_bit   = sda_s;
    // Data line edges while the clock stays high mark frame boundaries
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/wcmd_regfile.sv
module wcmd_regfile #(
    parameter int N_CH = 4,
    parameter int N_DR = 4,
    parameter int DW   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_CH*N_DR*DW-1:0]    dr_init,
    input  logic                       wr_en,
    input  logic [$clog2(N_CH)-1:0]    wr_ch,
    input  logic [DW-1:0]              wr_data,
    input  logic                       rd_is_dr,
    input  logic [$clog2(N_CH)-1:0]    rd_ch,
    input  logic [$clog2(N_DR)-1:0]    rd_reg,
    output logic [DW-1:0]              rd_data,
    output logic [N_CH*DW-1:0]         wcr_flat
);

    logic [DW-1:0] dr_q  [N_CH][N_DR];
    logic [DW-1:0] wcr_q [N_CH];
    logic          copy_pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) copy_pend <= 1'b1;
        else        copy_pend <= 1'b0;
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        for (genvar r = 0; r < N_DR; r++) begin : g_dr
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) dr_q[c][r] <= dr_init[(c*N_DR+r)*DW +: DW];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                wcr_q[c] <= '0;
            end else if (copy_pend) begin
                wcr_q[c] <= dr_q[c][0];
            end else if (wr_en && (wr_ch == c)) begin
                wcr_q[c] <= wr_data;
            end
        end

        assign wcr_flat[c*DW +: DW] = wcr_q[c];

        // R1
        pwrup_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
            copy_pend |=> (wcr_q[c] == $past(dr_q[c][0])));

        // R4
        wcr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !copy_pend && (wr_ch == c)) |=> (wcr_q[c] == $past(wr_data)));
    end

    assign rd_data = rd_is_dr ? dr_q[rd_ch][rd_reg] : wcr_q[rd_ch];

endmodule

// File: rtl/wcmd_ctrl.sv
module wcmd_ctrl
    import wcmd_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_hi,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             sda_bit,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic [3:0]       dev_addr,
    input  logic [DW-1:0]    rd_data,
    output logic             sda_pull,
    output logic             wr_en,
    output logic [SEL_W-1:0] wr_ch,
    output logic [DW-1:0]    wr_data,
    output logic             rd_is_dr,
    output logic [SEL_W-1:0] rd_ch,
    output logic [SEL_W-1:0] rd_reg
);

    ctl_state_e state_q, state_d;
    logic [7:0] shreg;
    logic [7:0] instr_q;
    logic [DW-1:0] tx_q;
    logic [2:0] bit_cnt;
    logic       addr_ok;
    logic       op_ok;
    logic       last_bit;

    assign addr_ok  = (shreg[7:4] == TYPE_ID) && (shreg[3:0] == dev_addr);
    assign op_ok    = (shreg[7:4] == OP_RD_WCR) || (shreg[7:4] == OP_WR_WCR) ||
                      (shreg[7:4] == OP_RD_DR);
    assign last_bit = (bit_cnt == 3'd7);

    assign wr_ch    = instr_q[SEL_W-1:0];
    assign rd_ch    = instr_q[SEL_W-1:0];
    assign rd_reg   = instr_q[2*SEL_W-1:SEL_W];
    assign rd_is_dr = (instr_q[7:4] == OP_RD_DR);
    assign wr_data  = shreg[DW-1:0];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next-state decode
    always_comb begin
        state_d = state_q;
        if (start_det) begin
            state_d = S_ADDR_RX;
        end else if (stop_det) begin
            state_d = S_IDLE;
        end else begin
            unique case (state_q)
                S_IDLE:      state_d = S_IDLE;
                S_ADDR_RX:   if (scl_rise && last_bit) state_d = S_ADDR_CHK;
                S_ADDR_CHK:  if (scl_fall) state_d = addr_ok ? S_ADDR_ACK : S_IDLE;
                S_ADDR_ACK:  if (scl_fall) state_d = S_INSTR_RX;
                S_INSTR_RX:  if (scl_rise && last_bit) state_d = S_INSTR_CHK;
                S_INSTR_CHK: if (scl_fall) state_d = op_ok ? S_INSTR_ACK : S_IDLE;
                S_INSTR_ACK: if (scl_fall)
                                 state_d = (instr_q[7:4] == OP_WR_WCR) ? S_WDATA_RX : S_RDATA_TX;
                S_WDATA_RX:  if (scl_rise && last_bit) state_d = S_WDATA_CHK;
                S_WDATA_CHK: if (scl_fall) state_d = S_WDATA_ACK;
                S_WDATA_ACK: if (scl_fall) state_d = S_WAIT_STOP;
                S_RDATA_TX:  if (scl_fall && last_bit) state_d = S_MACK;
                S_MACK:      if (scl_rise) state_d = S_WAIT_STOP;
                S_WAIT_STOP: state_d = S_WAIT_STOP;
                default:     state_d = S_IDLE;
            endcase
        end
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_pull <= 1'b0;
            wr_en    <= 1'b0;
            shreg    <= '0;
            instr_q  <= '0;
            tx_q     <= '0;
            bit_cnt  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det || stop_det) begin
                sda_pull <= 1'b0;
                bit_cnt  <= '0;
            end else begin
                unique case (state_q)
                    S_ADDR_RX, S_INSTR_RX, S_WDATA_RX: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[6:0], sda_bit};
                            bit_cnt <= bit_cnt + 3'd1;
                        end
                    end
                    S_ADDR_CHK: begin
                        if (scl_fall) sda_pull <= addr_ok;
                    end
                    S_ADDR_ACK: begin
                        if (scl_fall) begin
                            sda_pull <= 1'b0;
                            bit_cnt  <= '0;
                        end
                    end
                    S_INSTR_CHK: begin
                        if (scl_fall) begin
                            instr_q  <= shreg;
                            sda_pull <= op_ok;
                        end
                    end
                    S_INSTR_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (instr_q[7:4] == OP_WR_WCR) begin
                                sda_pull <= 1'b0;
                            end else begin
                                sda_pull <= ~rd_data[DW-1];
                                tx_q     <= {rd_data[DW-2:0], 1'b0};
                            end
                        end
                    end
                    S_WDATA_CHK: begin
                        if (scl_fall) begin
                            sda_pull <= 1'b1;
                            wr_en    <= 1'b1;
                        end
                    end
                    S_WDATA_ACK: begin
                        if (scl_fall) sda_pull <= 1'b0;
                    end
                    S_RDATA_TX: begin
                        if (scl_fall) begin
                            bit_cnt <= bit_cnt + 3'd1;
                            if (last_bit) begin
                                sda_pull <= 1'b0;
                            end else begin
                                sda_pull <= ~tx_q[DW-1];
                                tx_q     <= {tx_q[DW-2:0], 1'b0};
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R10
    pull_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_hi && !scl_rise) |-> $stable(sda_pull));

    // R9
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state_q == S_IDLE && !sda_pull));

    // R7
    wr_opcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (instr_q[7:4] == OP_WR_WCR));

endmodule

// File: rtl/wiper_cmd_if.sv
module wiper_cmd_if #(
    parameter int N_CH        = 4,
    parameter int N_DR        = 4,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    scl_in,
    input  logic                    sda_in,
    input  logic [3:0]              dev_addr,
    input  logic [N_CH*N_DR*DW-1:0] dr_init,
    output logic                    sda_pull,
    output logic [N_CH*DW-1:0]      wiper_pos
);

    localparam int CH_W = $clog2(N_CH);
    localparam int DR_W = $clog2(N_DR);

    logic            scl_hi, scl_rise, scl_fall, sda_bit, start_det, stop_det;
    logic            wr_en, rd_is_dr;
    logic [CH_W-1:0] wr_ch, rd_ch;
    logic [DR_W-1:0] rd_reg;
    logic [DW-1:0]   wr_data, rd_data;

    wcmd_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_hi    (scl_hi),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_bit   (sda_bit),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    wcmd_ctrl #(.DW(DW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_hi    (scl_hi),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_bit   (sda_bit),
        .start_det (start_det),
        .stop_det  (stop_det),
        .dev_addr  (dev_addr),
        .rd_data   (rd_data),
        .sda_pull  (sda_pull),
        .wr_en     (wr_en),
        .wr_ch     (wr_ch),
        .wr_data   (wr_data),
        .rd_is_dr  (rd_is_dr),
        .rd_ch     (rd_ch),
        .rd_reg    (rd_reg)
    );

    wcmd_regfile #(.N_CH(N_CH), .N_DR(N_DR), .DW(DW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .dr_init  (dr_init),
        .wr_en    (wr_en),
        .wr_ch    (wr_ch),
        .wr_data  (wr_data),
        .rd_is_dr (rd_is_dr),
        .rd_ch    (rd_ch),
        .rd_reg   (rd_reg),
        .rd_data  (rd_data),
        .wcr_flat (wiper_pos)
    );

endmodule

// File: tb/wiper_cmd_if_bench.sv
`timescale 1ns/1ps
module wiper_cmd_if_bench;

    localparam logic [3:0] DEV = 4'b1010;
    // vector: kind[17:16] (0 write, 1 read, 3 bad opcode), instr[15:8], data[7:0]
    localparam int NV = 12;
    localparam logic [17:0] VEC [NV] = '{
        {2'd0, 8'hA0, 8'h5A},
        {2'd1, 8'h90, 8'h00},
        {2'd0, 8'hAF, 8'hC3},
        {2'd1, 8'h93, 8'h00},
        {2'd1, 8'h99, 8'h00},
        {2'd1, 8'hBE, 8'h00},
        {2'd1, 8'hB1, 8'h00},
        {2'd1, 8'hB8, 8'h00},
        {2'd3, 8'hC1, 8'h77},
        {2'd3, 8'h21, 8'h66},
        {2'd0, 8'hA2, 8'hFF},
        {2'd1, 8'h92, 8'h00}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         scl_m = 1'b1;
    logic         sda_m = 1'b1;
    logic         sda_bus;
    logic         sda_pull;
    logic [127:0] dr_init;
    logic [31:0]  wiper_pos;
    logic [7:0]   m_wcr [4];
    int           n_chk = 0;
    int           n_fail = 0;
    int           r10_viol = 0;
    logic         prev_scl = 1'b1;
    logic         prev_pull = 1'b0;

    always #4 clk = ~clk;

    assign sda_bus = sda_m & ~sda_pull;

    wiper_cmd_if u_wiper_cmd_if (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_m),
        .sda_in    (sda_bus),
        .dev_addr  (DEV),
        .dr_init   (dr_init),
        .sda_pull  (sda_pull),
        .wiper_pos (wiper_pos)
    );

    function automatic logic [7:0] pre(input int c, input int r);
        return 8'((c << 6) | (r << 4) | (c + r + 5));
    endfunction

    initial begin
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++)
                dr_init[(c*4+r)*8 +: 8] = pre(c, r);
    end

    // R10 monitor: pull must not move while the bus clock stays high
    always @(negedge clk) begin
        if (rst_n && scl_m && prev_scl && (sda_pull != prev_pull)) r10_viol++;
        prev_scl  <= scl_m;
        prev_pull <= sda_pull;
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (10) @(negedge clk);
    endtask

    task automatic bitx(input logic v, output logic r);
        sda_m = v; wq();
        scl_m = 1'b1; wq();
        r = sda_bus; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_start();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        bus_start();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic d;
        for (int i = 7; i >= 0; i--) bitx(b[i], d);
        bitx(1'b1, d);
        acked = ~d;
    endtask

    task automatic recv_byte(output logic [7:0] b);
        logic d;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            bitx(1'b1, d);
            b = {b[6:0], d};
        end
        bitx(1'b1, d);
    endtask

    task automatic check_all_wipers(input string req);
        for (int c = 0; c < 4; c++) check(req, wiper_pos[c*8 +: 8], m_wcr[c]);
    endtask

    logic       ack;
    logic [7:0] rv;
    logic       dummy;

    initial begin
        for (int c = 0; c < 4; c++) m_wcr[c] = pre(c, 0);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1: power-up copy from data register 0 and released line
        check_all_wipers("R1");
        check("R1", {7'd0, sda_pull}, 8'd0);

        // Table-driven commands
        for (int v = 0; v < NV; v++) begin
            logic [1:0] kind;
            logic [7:0] ins, dat;
            int         ch, rg;
            kind = VEC[v][17:16];
            ins  = VEC[v][15:8];
            dat  = VEC[v][7:0];
            ch   = int'(ins[1:0]);
            rg   = int'(ins[3:2]);
            bus_start();
            send_byte({4'b0101, DEV}, ack);
            check("R2", {7'd0, ack}, 8'd1);
            send_byte(ins, ack);
            if (kind == 2'd0) begin
                check("R4", {7'd0, ack}, 8'd1);
                send_byte(dat, ack);
                check("R4", {7'd0, ack}, 8'd1);
                bus_stop();
                m_wcr[ch] = dat;
                check("R4", wiper_pos[ch*8 +: 8], dat);
            end else if (kind == 2'd1) begin
                check(ins[7:4] == 4'b1011 ? "R6" : "R5", {7'd0, ack}, 8'd1);
                recv_byte(rv);
                bus_stop();
                if (ins[7:4] == 4'b1011) check("R6", rv, pre(ch, rg));
                else                     check("R5", rv, m_wcr[ch]);
            end else begin
                check("R7", {7'd0, ack}, 8'd0);
                send_byte(dat, ack);
                check("R7", {7'd0, ack}, 8'd0);
                bus_stop();
                check_all_wipers("R7");
            end
        end

        // R3: wrong type nibble, then wrong device address
        for (int k = 0; k < 2; k++) begin
            bus_start();
            send_byte(k == 0 ? {4'b0110, DEV} : {4'b0101, ~DEV}, ack);
            check("R3", {7'd0, ack}, 8'd0);
            send_byte(8'hA1, ack);
            check("R3", {7'd0, ack}, 8'd0);
            send_byte(8'h44, ack);
            check("R3", {7'd0, ack}, 8'd0);
            bus_stop();
            check_all_wipers("R3");
        end

        // R8: abort a half-received write with a repeated START, then STOP
        bus_start();
        send_byte({4'b0101, DEV}, ack);
        send_byte(8'hA2, ack);
        for (int i = 0; i < 4; i++) bitx(i >= 2, dummy);
        bus_rstart();
        bus_stop();
        check("R8", wiper_pos[2*8 +: 8], m_wcr[2]);

        // R8: abort and restart straight into a full write
        bus_start();
        send_byte({4'b0101, DEV}, ack);
        send_byte(8'hA2, ack);
        for (int i = 0; i < 4; i++) bitx(i >= 2, dummy);
        bus_rstart();
        send_byte({4'b0101, DEV}, ack);
        check("R8", {7'd0, ack}, 8'd1);
        send_byte(8'hA2, ack);
        send_byte(8'h81, ack);
        check("R8", {7'd0, ack}, 8'd1);
        bus_stop();
        m_wcr[2] = 8'h81;
        check("R8", wiper_pos[2*8 +: 8], 8'h81);

        // R9: STOP in the middle of the address byte
        bus_start();
        for (int i = 0; i < 3; i++) bitx(1'b0, dummy);
        bus_stop();
        check("R9", {7'd0, sda_pull}, 8'd0);
        bus_start();
        send_byte({4'b0101, DEV}, ack);
        check("R9", {7'd0, ack}, 8'd1);
        send_byte(8'h91, ack);
        recv_byte(rv);
        bus_stop();
        check("R9", rv, m_wcr[1]);

        // R10: pull never moved while the clock was high
        check("R10", 8'(r10_viol), 8'd0);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog all act=timeout exp=done");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule